// File: doc/BRIEF.md
# Environment Configuration Register Pair

This block holds two environment configuration registers, one owned by the machine privilege level and one by the supervisor privilege level. Each register carries three controls for cache-block management instructions: a zero-block enable, a clean/flush enable, and a two-bit invalidate control. The instruction logic reads these controls directly from dedicated output pins, one set per privilege level. It combines them with the current privilege to decide whether an operation is allowed, whether it is promoted to a flush, or whether it traps.

Software reaches the registers through a plain CSR access port. The port takes an access strobe, a 12-bit address, write data, a write enable, the current privilege, and a strap that says whether supervisor mode exists. Read data is combinational from the address.

A permitted write is stored at the next rising clock edge. The stored value is legalized: only the three control fields are kept, and the reserved invalidate code is folded onto the disabled code. A forbidden access raises an illegal flag during that access cycle, returns zero read data, and changes nothing.

This is a control port, so it has no valid/ready handshake and no back-pressure. Every strobed access completes in its own cycle.

Top module: `envcfg_csr_pair`

## Requirements
- R1: With `csr_en` high, address 0x30A selects the machine register and 0x10A selects the supervisor register. `csr_rdata` returns the selected register in the same cycle: zero-block enable at bit 7, clean/flush enable at bit 6, invalidate control at bits 5:4.
- R2: A write of 2'b10 to the invalidate field stores 2'b00. The values 2'b00, 2'b01 and 2'b11 are stored as written.
- R3: A write changes only bits 7, 6 and 5:4. All other bits of `csr_rdata` read as zero, whatever was written to them.
- R4: After reset, both registers and all exposed field pins are zero.
- R5: The machine register (0x30A) may be accessed only when `priv` is 2'b11 (machine). Any other privilege raises `csr_illegal` in that cycle and leaves the register unchanged.
- R6: The supervisor register (0x10A) may be accessed only when `s_present` is 1 and `priv` is 2'b11 or 2'b01 (supervisor). Otherwise `csr_illegal` is raised and the register is left unchanged. User is 2'b00; 2'b10 grants no access.
- R7: A permitted write appears on the exposed field pins of the written register from the cycle after the clock edge that stores it. The other register's pins are unaffected.
- R8: An access to any other address, or a cycle with `csr_en` low, never raises `csr_illegal`, returns zero read data and changes neither register.
- R9: While `csr_illegal` is high, `csr_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Access strobe for this cycle |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write enable, qualified by `csr_en` |
| csr_wdata | input | XLEN | Write data |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| s_present | input | 1 | Strap: supervisor mode implemented |
| csr_rdata | output | XLEN | Combinational read data |
| csr_illegal | output | 1 | Forbidden access in this cycle |
| m_zero_en | output | 1 | Machine register zero-block enable |
| m_clean_en | output | 1 | Machine register clean/flush enable |
| m_inval_ctl | output | 2 | Machine register invalidate control |
| s_zero_en | output | 1 | Supervisor register zero-block enable |
| s_clean_en | output | 1 | Supervisor register clean/flush enable |
| s_inval_ctl | output | 2 | Supervisor register invalidate control |

## Verification
The assertions assume that `priv`, `s_present` and the access inputs are stable around the rising edge. They also assume the access inputs are driven to known values whenever `csr_en` is high; the register logic otherwise trusts those inputs. The stimulus keeps within these assumptions by changing every input on the falling edge only. It drives the high write-data bits all ones, so stray storage would show up. It walks every privilege code, including the reserved 2'b10, against both register addresses and a neighbouring address, with the strap both set and cleared.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;

  localparam int ZERO_EN_BIT  = 7;
  localparam int CLEAN_EN_BIT = 6;
  localparam int INVAL_LO_BIT = 4;
  localparam int INVAL_HI_BIT = 5;

  localparam logic [11:0] ADDR_MACH_CFG  = 12'h30A;
  localparam logic [11:0] ADDR_SUPER_CFG = 12'h10A;

  localparam logic [1:0] INVAL_RESERVED = 2'b10;
  localparam logic [1:0] INVAL_OFF      = 2'b00;

  typedef struct packed {
    logic       zero_en;
    logic       clean_en;
    logic [1:0] inval;
  } cfg_fields_t;

  function automatic logic [1:0] fold_inval(input logic [1:0] wr);
    return (wr == INVAL_RESERVED) ? INVAL_OFF : wr;
  endfunction

endpackage

// File: rtl/envcfg_access_chk.sv
module envcfg_access_chk
  import envcfg_pkg::*;
#(
  parameter logic [11:0] MACH_ADDR  = ADDR_MACH_CFG,
  parameter logic [11:0] SUPER_ADDR = ADDR_SUPER_CFG
) (
  input  logic        csr_en,
  input  logic [11:0] csr_addr,
  input  logic [1:0]  priv,
  input  logic        s_present,
  output logic        hit_mach,
  output logic        hit_super,
  output logic        ok_mach,
  output logic        ok_super,
  output logic        illegal
);

  logic is_mach, is_super;

  always_comb begin
    is_mach   = (priv == PRIV_MACH);
    is_super  = (priv == PRIV_SUPER);
    hit_mach  = csr_en && (csr_addr == MACH_ADDR);
    hit_super = csr_en && (csr_addr == SUPER_ADDR);
    ok_mach   = hit_mach && is_mach;
    ok_super  = hit_super && s_present && (is_mach || is_super);
    illegal   = (hit_mach && !ok_mach) || (hit_super && !ok_super);
  end

endmodule

// File: rtl/envcfg_field_reg.sv
module envcfg_field_reg
  import envcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  output cfg_fields_t     cfg_q
);

  cfg_fields_t cfg_d;

  always_comb begin
    cfg_d          = cfg_q;
    cfg_d.zero_en  = wdata[ZERO_EN_BIT];
    cfg_d.clean_en = wdata[CLEAN_EN_BIT];
    cfg_d.inval    = fold_inval(wdata[INVAL_HI_BIT:INVAL_LO_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  // R2: reserved invalidate code never held
  assert_no_reserved_inval_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.inval != INVAL_RESERVED);

  // R5 / R6: register holds without a write strobe
  assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/envcfg_csr_pair.sv
module envcfg_csr_pair
  import envcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      priv,
  input  logic            s_present,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            m_zero_en,
  output logic            m_clean_en,
  output logic [1:0]      m_inval_ctl,
  output logic            s_zero_en,
  output logic            s_clean_en,
  output logic [1:0]      s_inval_ctl
);

  localparam int NREG = 2;
  localparam int IDX_M = 0;
  localparam int IDX_S = 1;
  localparam logic [XLEN-1:0] FIELD_MASK = XLEN'((1 << (ZERO_EN_BIT + 1)) - (1 << INVAL_LO_BIT));

  logic        hit_m, hit_s, ok_m, ok_s;
  logic [NREG-1:0] wr_sel;
  cfg_fields_t     regs [NREG];

  envcfg_access_chk u_chk (
    .csr_en    (csr_en),
    .csr_addr  (csr_addr),
    .priv      (priv),
    .s_present (s_present),
    .hit_mach  (hit_m),
    .hit_super (hit_s),
    .ok_mach   (ok_m),
    .ok_super  (ok_s),
    .illegal   (csr_illegal)
  );

  assign wr_sel[IDX_M] = ok_m && csr_we;
  assign wr_sel[IDX_S] = ok_s && csr_we;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    envcfg_field_reg #(.XLEN(XLEN)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_sel[g]),
      .wdata (csr_wdata),
      .cfg_q (regs[g])
    );
  end

  function automatic logic [XLEN-1:0] place(input cfg_fields_t f);
    logic [XLEN-1:0] v;
    v = '0;
    v[ZERO_EN_BIT]               = f.zero_en;
    v[CLEAN_EN_BIT]              = f.clean_en;
    v[INVAL_HI_BIT:INVAL_LO_BIT] = f.inval;
    return v;
  endfunction

  always_comb begin
    csr_rdata = '0;
    if (ok_m)      csr_rdata = place(regs[IDX_M]);
    else if (ok_s) csr_rdata = place(regs[IDX_S]);
  end

  assign m_zero_en   = regs[IDX_M].zero_en;
  assign m_clean_en  = regs[IDX_M].clean_en;
  assign m_inval_ctl = regs[IDX_M].inval;
  assign s_zero_en   = regs[IDX_S].zero_en;
  assign s_clean_en  = regs[IDX_S].clean_en;
  assign s_inval_ctl = regs[IDX_S].inval;

  // R9: forbidden access returns zero
  assert_zero_on_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  // R3: only the field bits can ever be nonzero
  assert_unused_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~FIELD_MASK) == '0);

  // R5: a forbidden access changes no exposed field
  assert_illegal_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> $stable({m_zero_en, m_clean_en, m_inval_ctl,
                             s_zero_en, s_clean_en, s_inval_ctl}));

  // R8: foreign addresses never flagged
  assert_foreign_not_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr != ADDR_MACH_CFG && csr_addr != ADDR_SUPER_CFG) |-> !csr_illegal);

endmodule

// File: tb/envcfg_csr_pair_tb.sv
module envcfg_csr_pair_tb;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            csr_en = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic            csr_we = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [1:0]      priv = 2'b11;
  logic            s_present = 1'b1;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_illegal;
  logic            m_zero_en, m_clean_en, s_zero_en, s_clean_en;
  logic [1:0]      m_inval_ctl, s_inval_ctl;

  int total = 0;
  int bad = 0;
  logic [7:0] cur_m = 8'h00;
  logic [7:0] cur_s = 8'h00;

  always #2 clk = ~clk;

  envcfg_csr_pair #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .priv(priv), .s_present(s_present),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .m_zero_en(m_zero_en), .m_clean_en(m_clean_en), .m_inval_ctl(m_inval_ctl),
    .s_zero_en(s_zero_en), .s_clean_en(s_clean_en), .s_inval_ctl(s_inval_ctl)
  );

  typedef struct packed {
    logic [1:0]  pv;
    logic        sp;
    logic [11:0] addr;
    logic        we;
    logic [15:0] wd;
    logic        ill;
    logic [7:0]  em;
    logic [7:0]  es;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{2'b11, 1'b1, 12'h30A, 1'b1, 16'hFFF0, 1'b0, 8'hF0, 8'h00}, // R3 R1
    '{2'b11, 1'b1, 12'h10A, 1'b1, 16'h00A0, 1'b0, 8'hF0, 8'h80}, // R2
    '{2'b11, 1'b1, 12'h30A, 1'b1, 16'h0060, 1'b0, 8'h40, 8'h80}, // R2
    '{2'b01, 1'b1, 12'h30A, 1'b1, 16'h00F0, 1'b1, 8'h40, 8'h80}, // R5
    '{2'b00, 1'b1, 12'h10A, 1'b1, 16'h0010, 1'b1, 8'h40, 8'h80}, // R6
    '{2'b01, 1'b1, 12'h10A, 1'b1, 16'h0050, 1'b0, 8'h40, 8'h50}, // R6 R7
    '{2'b11, 1'b0, 12'h10A, 1'b1, 16'h00F0, 1'b1, 8'h40, 8'h50}, // R6
    '{2'b01, 1'b0, 12'h10A, 1'b0, 16'h0000, 1'b1, 8'h40, 8'h50}, // R6
    '{2'b01, 1'b1, 12'h10A, 1'b0, 16'h0000, 1'b0, 8'h40, 8'h50}, // R1
    '{2'b11, 1'b1, 12'h30B, 1'b1, 16'h00FF, 1'b0, 8'h40, 8'h50}, // R8
    '{2'b10, 1'b1, 12'h10A, 1'b1, 16'h00F0, 1'b1, 8'h40, 8'h50}, // R6
    '{2'b11, 1'b1, 12'h30A, 1'b1, 16'h0030, 1'b0, 8'h30, 8'h50}, // R2
    '{2'b11, 1'b1, 12'h30A, 1'b1, 16'h0010, 1'b0, 8'h10, 8'h50}, // R2 R7
    '{2'b00, 1'b1, 12'h30A, 1'b0, 16'h0000, 1'b1, 8'h10, 8'h50}  // R5 R9
  };

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pins_m();
    return {m_zero_en, m_clean_en, m_inval_ctl, 4'h0};
  endfunction
  function automatic logic [7:0] pins_s();
    return {s_zero_en, s_clean_en, s_inval_ctl, 4'h0};
  endfunction

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] exp_rd;
    repeat (3) @(negedge clk);
    // R4: reset state
    check("R4 m pins", XLEN'(pins_m()), '0);
    check("R4 s pins", XLEN'(pins_s()), '0);
    rst_n = 1'b1;
    @(negedge clk);
    csr_en = 1'b1; csr_addr = 12'h30A; priv = 2'b11; csr_we = 1'b0;
    #1 check("R4 m read", csr_rdata, '0);
    csr_addr = 12'h10A;
    #0.5 check("R4 s read", csr_rdata, '0);
    csr_en = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      csr_en = 1'b1; priv = VT[i].pv; s_present = VT[i].sp;
      csr_addr = VT[i].addr; csr_we = VT[i].we;
      csr_wdata = {{(XLEN-16){1'b1}}, VT[i].wd};
      #1;
      if (VT[i].ill) exp_rd = '0;
      else if (VT[i].addr == 12'h30A) exp_rd = XLEN'(cur_m);
      else if (VT[i].addr == 12'h10A) exp_rd = XLEN'(cur_s);
      else exp_rd = '0;
      check($sformatf("R5/R6 illegal row %0d", i), XLEN'(csr_illegal), XLEN'(VT[i].ill));
      check($sformatf("R1/R9 rdata row %0d", i), csr_rdata, exp_rd);
      @(negedge clk);
      csr_en = 1'b0; csr_we = 1'b0;
      check($sformatf("R7/R2 m pins row %0d", i), XLEN'(pins_m()), XLEN'(VT[i].em));
      check($sformatf("R7/R2 s pins row %0d", i), XLEN'(pins_s()), XLEN'(VT[i].es));
      cur_m = VT[i].em; cur_s = VT[i].es;
    end

    // R8: write strobe with csr_en low is ignored
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b1; priv = 2'b11; s_present = 1'b1;
    csr_addr = 12'h30A; csr_wdata = '1;
    #1 check("R8 no illegal when idle", XLEN'(csr_illegal), '0);
    check("R8 idle rdata", csr_rdata, '0);
    @(negedge clk);
    csr_we = 1'b0;
    check("R8 m unchanged", XLEN'(pins_m()), XLEN'(cur_m));

    // R1: read back stored supervisor value through the port with full data check
    csr_en = 1'b1; csr_addr = 12'h10A; priv = 2'b11;
    #1 check("R1 s readback", csr_rdata, XLEN'(cur_s));
    csr_en = 1'b0;

    // R4: reset mid-run clears both
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R4 m after reset", XLEN'(pins_m()), '0);
    check("R4 s after reset", XLEN'(pins_s()), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule